// File: doc/BRIEF.md
# Integer Arithmetic Unit with Condition Flags

This block computes one integer operation per cycle on two operands of `W` bits (32 by default) and an optional third operand used as an accumulator. The operation set covers add, subtract, reverse subtract, two compare forms, a low-word multiply and two multiply-with-accumulate forms. The result is produced combinationally in the same cycle as the inputs. A write strobe tells the surrounding datapath whether the result should be stored.

Four condition flags are held in a register. Negative is bit 3, zero is bit 2, carry is bit 1 and overflow is bit 0. The flags are loaded at a rising clock edge only when the caller asks for it through a set-flags input. This lets a sequence of operations leave an earlier comparison outcome intact until a later instruction chooses to replace it. A parameter selects how the multiplier is built: either the native product operator or an unrolled shift-and-add array.

Top module: `alu_core`

## Requirements
- R1: Opcode 0 (add) gives `a+b` modulo 2^W. When flags are set, carry is the unsigned carry-out and overflow marks a signed result outside the W-bit range.
- R2: Opcode 1 (subtract) gives `a-b`. When flags are set, carry is 1 when no borrow occurs (a >= b unsigned) and 0 on borrow, and overflow marks signed overflow.
- R3: Opcode 2 (reverse subtract) gives `b-a`, with carry and overflow defined as in R2 but with the operands swapped.
- R4: Opcode 3 (compare) sets the flags of `a-b` as in R2 and drives the write strobe low.
- R5: Opcode 4 (compare-negative) sets the flags of `a+b` as in R1 and drives the write strobe low.
- R6: Opcode 5 (multiply) gives the low W bits of `a*b`.
- R7: Opcode 6 (multiply-accumulate) gives `acc + a*b` modulo 2^W.
- R8: Opcode 7 (multiply-subtract) gives `acc - a*b` modulo 2^W.
- R9: A flag-setting multiply (opcodes 5, 6 or 7) loads negative and zero and keeps carry (bit 1) and overflow (bit 0) unchanged.
- R10: While set-flags is low, all four flag bits keep their values across a clock edge, whatever the opcode.
- R11: When flags are set, negative (bit 3) equals result bit W-1, and zero (bit 2) is 1 exactly when the whole result is 0.
- R12: The write strobe is high for opcodes 0, 1, 2, 5, 6 and 7.
- R13: A synchronous active-high reset clears all four flags at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags load on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_i | input | 3 | Operation code (0 to 7, see requirements) |
| src_a_i | input | W | First operand |
| src_b_i | input | W | Second operand |
| src_acc_i | input | W | Accumulator operand for the multiply-accumulate forms |
| set_flags_i | input | 1 | Load the flags at the next edge |
| result_o | output | W | Combinational result |
| wr_en_o | output | 1 | Result write strobe |
| flags_o | output | 4 | Registered flags {N, Z, C, V} |

## Verification
The hardest case to reach is a flag-setting multiply that follows a flag-setting arithmetic operation that left carry or overflow at 1. Only that order shows whether the multiply really keeps those two bits rather than clearing them. The bench sweeps every operand pair and every opcode on a 6-bit configuration. It interleaves the operations and toggles set-flags in a pattern unrelated to the opcode, so that multiplies regularly land on top of non-zero carry and overflow values and flag-hold cycles fall between them.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_RSB = 3'd2,
      OP_CMP = 3'd3,
      OP_CMN = 3'd4,
      OP_MUL = 3'd5,
      OP_MLA = 3'd6,
      OP_MLS = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } alu_flags_t;

   localparam int FLAG_BITS = 4;

   function automatic logic op_is_mul(input alu_op_e op);
      return (op == OP_MUL) || (op == OP_MLA) || (op == OP_MLS);
   endfunction

   function automatic logic op_is_cmp(input alu_op_e op);
      return (op == OP_CMP) || (op == OP_CMN);
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         inv_a_i,
   input  logic         inv_b_i,
   output logic [W-1:0] sum_o,
   output logic         carry_o,
   output logic         ovf_o
);
   localparam int MSB = W - 1;

   logic [W-1:0] x, y;
   logic         cin;
   logic [W:0]   full;

   always_comb begin
      x    = inv_a_i ? ~a_i : a_i;
      y    = inv_b_i ? ~b_i : b_i;
      cin  = inv_a_i | inv_b_i;
      full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
   end

   assign sum_o   = full[W-1:0];
   assign carry_o = full[W];
   assign ovf_o   = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);

endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
   parameter int W         = 32,
   parameter int MUL_STYLE = 0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] acc_i,
   input  logic         use_acc_i,
   input  logic         neg_prod_i,
   output logic [W-1:0] res_o
);
   logic [W-1:0] prod;
   logic [W-1:0] base;

   generate
      if (MUL_STYLE == 0) begin : g_native
         always_comb prod = a_i * b_i;
      end else begin : g_shift_add
         always_comb begin
            prod = '0;
            for (int i = 0; i < W; i++) begin
               if (b_i[i]) prod = prod + (a_i << i);
            end
         end
      end
   endgenerate

   always_comb begin
      base  = use_acc_i ? acc_i : '0;
      res_o = neg_prod_i ? (base - prod) : (base + prod);
   end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       load_nz_i,
   input  logic       load_cv_i,
   input  alu_flags_t next_i,
   output alu_flags_t q_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q_o <= '0;
      end else begin
         if (load_nz_i) begin
            q_o.n <= next_i.n;
            q_o.z <= next_i.z;
         end
         if (load_cv_i) begin
            q_o.c <= next_i.c;
            q_o.v <= next_i.v;
         end
      end
   end
endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int W         = 32,
   parameter int MUL_STYLE = 0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [2:0]           op_i,
   input  logic [W-1:0]         src_a_i,
   input  logic [W-1:0]         src_b_i,
   input  logic [W-1:0]         src_acc_i,
   input  logic                 set_flags_i,
   output logic [W-1:0]         result_o,
   output logic                 wr_en_o,
   output logic [FLAG_BITS-1:0] flags_o
);
   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("alu_core: W must be at least 2");
      end
      if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_style
         $error("alu_core: MUL_STYLE must be 0 or 1");
      end
   endgenerate

   alu_op_e    op;
   logic       is_mul;
   logic       swap, inv_a, inv_b;
   logic [W-1:0] as_sum, mul_res;
   logic       as_c, as_v;
   alu_flags_t nxt, cur;

   assign op     = alu_op_e'(op_i);
   assign is_mul = op_is_mul(op);

   always_comb begin
      swap  = 1'b0;
      inv_a = 1'b0;
      inv_b = 1'b0;
      unique case (op)
         OP_SUB, OP_CMP: inv_b = 1'b1;
         OP_RSB:         begin swap = 1'b1; inv_b = 1'b1; end
         default:        ;
      endcase
   end

   alu_addsub #(.W(W)) u_addsub (
      .a_i     (swap ? src_b_i : src_a_i),
      .b_i     (swap ? src_a_i : src_b_i),
      .inv_a_i (inv_a),
      .inv_b_i (inv_b),
      .sum_o   (as_sum),
      .carry_o (as_c),
      .ovf_o   (as_v)
   );

   alu_mul #(.W(W), .MUL_STYLE(MUL_STYLE)) u_mul (
      .a_i        (src_a_i),
      .b_i        (src_b_i),
      .acc_i      (src_acc_i),
      .use_acc_i  (op != OP_MUL),
      .neg_prod_i (op == OP_MLS),
      .res_o      (mul_res)
   );

   assign result_o = is_mul ? mul_res : as_sum;
   assign wr_en_o  = !op_is_cmp(op);

   always_comb begin
      nxt.n = result_o[MSB];
      nxt.z = (result_o == '0);
      nxt.c = as_c;
      nxt.v = as_v;
   end

   alu_flag_reg u_flags (
      .clk       (clk),
      .rst       (rst),
      .load_nz_i (set_flags_i),
      .load_cv_i (set_flags_i && !is_mul),
      .next_i    (nxt),
      .q_o       (cur)
   );

   assign flags_o = cur;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst,
   input logic [2:0]   op_i,
   input logic         set_flags_i,
   input logic [W-1:0] result_o,
   input logic         wr_en_o,
   input logic [3:0]   flags_o
);
   // R13: synchronous clear
   a_r13_reset_clears: assert property (@(posedge clk) rst |=> flags_o == 4'b0000);

   // R10: flags hold without a request
   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      !set_flags_i |=> $stable(flags_o));

   // R9: multiplies keep carry and overflow
   a_r9_mul_keeps_cv: assert property (@(posedge clk) disable iff (rst)
      (set_flags_i && op_i >= 3'd5) |=> flags_o[1:0] == $past(flags_o[1:0]));

   // R11: negative and zero follow the result
   a_r11_n_flag: assert property (@(posedge clk) disable iff (rst)
      set_flags_i |=> flags_o[3] == $past(result_o[W-1]));
   a_r11_z_flag: assert property (@(posedge clk) disable iff (rst)
      set_flags_i |=> flags_o[2] == ($past(result_o) == '0));

   // R4, R5, R12: write strobe versus opcode
   a_r4_r5_no_write: assert property (@(posedge clk) disable iff (rst)
      (op_i == 3'd3 || op_i == 3'd4) |-> !wr_en_o);
   a_r12_write: assert property (@(posedge clk) disable iff (rst)
      (op_i != 3'd3 && op_i != 3'd4) |-> wr_en_o);
endmodule

bind alu_core alu_core_chk #(.W(W)) chk_i (
   .clk         (clk),
   .rst         (rst),
   .op_i        (op_i),
   .set_flags_i (set_flags_i),
   .result_o    (result_o),
   .wr_en_o     (wr_en_o),
   .flags_o     (flags_o)
);

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;
   localparam int W = 6;
   localparam int M = (1 << W) - 1;
   localparam int H = 1 << (W - 1);

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [2:0]   op = 3'd0;
   logic [W-1:0] a = '0, b = '0, acc = '0;
   logic         setf = 1'b0;
   logic [W-1:0] res;
   logic         wr;
   logic [3:0]   flags;

   int total = 0, bad = 0;
   bit done = 0;
   logic [3:0] exp_f = 4'b0000;

   always #10 clk = ~clk;

   alu_core #(.W(W), .MUL_STYLE(1)) dut_i (
      .clk(clk), .rst(rst), .op_i(op), .src_a_i(a), .src_b_i(b),
      .src_acc_i(acc), .set_flags_i(setf), .result_o(res),
      .wr_en_o(wr), .flags_o(flags)
   );

   function automatic int sx(input int v);
      return (v >= H) ? v - 2 * H : v;
   endfunction

   task automatic chk(input string req, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s op=%0d a=%0d b=%0d acc=%0d act=%0d exp=%0d",
                  req, op, a, b, acc, act, expv);
      end
   endtask

   task automatic run_vec(input int o, input int va, input int vb, input int vc, input bit sf);
      int r, c, v, s;
      string tag;
      @(negedge clk);
      op = 3'(o); a = W'(va); b = W'(vb); acc = W'(vc); setf = sf;
      c = 0; v = 0;
      case (o)
         0, 4: begin s = va + vb; r = s & M; c = s >> W;
                  s = sx(va) + sx(vb); v = (s >= H || s < -H); end
         1, 3: begin r = (va - vb) & M; c = (va >= vb);
                  s = sx(va) - sx(vb); v = (s >= H || s < -H); end
         2:    begin r = (vb - va) & M; c = (vb >= va);
                  s = sx(vb) - sx(va); v = (s >= H || s < -H); end
         5:    r = (va * vb) & M;
         6:    r = (vc + va * vb) & M;
         default: r = (vc - va * vb) & M;
      endcase
      case (o)
         0: tag = "R1"; 1: tag = "R2"; 2: tag = "R3"; 3: tag = "R4";
         4: tag = "R5"; 5: tag = "R6"; 6: tag = "R7"; default: tag = "R8";
      endcase
      #2;
      if (o != 3 && o != 4) chk(tag, int'(res), r);
      chk((o == 3 || o == 4) ? tag : "R12", int'(wr), (o == 3 || o == 4) ? 0 : 1);
      if (sf) begin
         exp_f[3] = r[W-1];
         exp_f[2] = (r == 0);
         if (o < 5) begin exp_f[1] = c[0]; exp_f[0] = v[0]; end
      end
      @(posedge clk); #2;
      if (!sf)       chk("R10", int'(flags), int'(exp_f));
      else if (o >= 5) chk("R9 R11", int'(flags), int'(exp_f));
      else           chk({tag, " R11"}, int'(flags), int'(exp_f));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 chk("R13", int'(flags), 0);
      @(negedge clk) rst = 1'b0;
      // explicit corners
      run_vec(0, M, 1, 0, 1);          // carry out, zero result
      run_vec(5, 3, 5, 0, 1);          // multiply keeps C set
      run_vec(0, H - 1, 1, 0, 1);      // signed overflow
      run_vec(7, 2, 3, 6, 1);          // mls to zero, V kept
      run_vec(1, 0, 1, 0, 0);          // no-request hold
      run_vec(3, 5, 5, 0, 1);          // compare equal: Z and C
      // full sweep
      for (int ia = 0; ia <= M; ia++) begin
         for (int ib = 0; ib <= M; ib++) begin
            for (int o = 0; o < 8; o++) begin
               run_vec(o, ia, ib, (ia * 7 + ib * 3 + o) & M, ((ia + ib + o) % 3) != 0);
            end
         end
      end
      // reset mid-run with flags set
      run_vec(0, M, M, 0, 1);
      @(negedge clk) rst = 1'b1; setf = 1'b0;
      @(posedge clk); #2 chk("R13", int'(flags), 0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule